// File: doc/BRIEF.md
# Sixteen-bit eight-operation processor core

A single-cycle processor core with a 16-bit datapath and eight 16-bit general registers. Each clock it takes one instruction word from a word-addressed instruction port, decodes it, and completes it in the same cycle. It can write a register, write a data word, or redirect the program counter. The eight operations are add, add-immediate, NAND, load-upper, load, store, branch-if-equal and jump-and-link. No other logic operation exists.

Both memory ports read combinationally. The data port writes on the rising clock edge while its write enable is high. The surrounding chip supplies the instruction and data storage. A jump-and-link whose low seven bits are not all zero acts as a halt. It stops the core for good, and a status output reports this.

Top module: `sq16_core`

## Requirements
- R1: While rst_ni is low, the program counter and all registers clear to zero and halted_o is low. After release, the first fetch is at address 0.
- R2: Opcode 000 (add) writes regB+regC into regA. Opcode 010 (NAND) writes ~(regB & regC) into regA. Fields: opcode [15:13], regA [12:10], regB [9:7], regC [2:0].
- R3: Opcode 001 (add-immediate) writes regB plus the immediate into regA. The immediate is bits [6:0], two's complement, sign-extended to 16 bits.
- R4: Opcode 011 (load-upper) writes bits [9:0] shifted left by 6 into regA, so the low 6 result bits are zero.
- R5: Opcodes 100 (load) and 101 (store) use regB plus the sign-extended 7-bit immediate as the data address. A load writes the read word into regA. A store drives regA on the write data and pulses the write enable for that cycle, and changes no register. The write enable is high only for a store.
- R6: Opcode 110 (branch-if-equal) moves to PC+1+immediate when regA equals regB, where PC is the branch's own address. Otherwise it moves to PC+1. Backward offsets work.
- R7: Opcode 111 with bits [6:0] zero (jump-and-link) jumps to the value of regB and writes PC+1 into regA. When regA and regB are the same register, the jump uses the value regB held before the write.
- R8: Register 0 always reads as zero, and writes aimed at it are discarded.
- R9: Opcode 111 with any nonzero bit in [6:0] halts the core. From the next cycle halted_o stays high, the fetch address no longer changes, and no register or memory write occurs.
- R10: Every operation other than a branch or a jump moves the fetch address to PC+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_addr_o | output | 16 | Instruction word address (the program counter) |
| imem_data_i | input | 16 | Instruction word at imem_addr_o |
| dmem_addr_o | output | 16 | Data word address |
| dmem_wdata_o | output | 16 | Data word to write |
| dmem_we_o | output | 1 | Data write enable, taken at the rising edge |
| dmem_rdata_i | input | 16 | Data word at dmem_addr_o |
| halted_o | output | 1 | High once a halt has executed |

## Verification
Registers are not visible at the ports, so every register result is checked by storing it and comparing the write address and data on the store cycle. A wrong sum, mask or link value shows up on the very next store that uses that register. A mistaken branch or jump target shows as a store from a skipped "poison" word, or as a store that never comes. Each shows in the cycle where the program path diverges. A halt that fails to freeze the core shows as a moving fetch address or a stray write one cycle after the halt.

// File: rtl/sq16_pkg.sv
package sq16_pkg;
  localparam int ILEN   = 16;
  localparam int OP_W   = 3;
  localparam int REG_AW = 3;
  localparam int NREG   = 1 << REG_AW;
  localparam int SIMM_W = 7;
  localparam int UIMM_W = 10;
  localparam int UIMM_SH = ILEN - UIMM_W;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 3'd0,
    OP_ADDI = 3'd1,
    OP_NAND = 3'd2,
    OP_LUI  = 3'd3,
    OP_LW   = 3'd4,
    OP_SW   = 3'd5,
    OP_BEQ  = 3'd6,
    OP_JALR = 3'd7
  } op_e;

  typedef struct packed {
    op_e               op;
    logic [REG_AW-1:0] ra;
    logic [REG_AW-1:0] rb;
    logic [REG_AW-1:0] rc;
    logic [ILEN-1:0]   imm;
    logic              uses_rc;
    logic              wr;
    logic              halt;
  } dec_t;
endpackage

// File: rtl/sq16_decode.sv
module sq16_decode
  import sq16_pkg::*;
(
  input  logic [ILEN-1:0] instr_i,
  output dec_t            dec_o
);
  logic [ILEN-1:0] simm, uimm;

  assign simm = {{(ILEN-SIMM_W){instr_i[SIMM_W-1]}}, instr_i[SIMM_W-1:0]};
  assign uimm = {instr_i[UIMM_W-1:0], {UIMM_SH{1'b0}}};

  always_comb begin
    dec_o.op      = op_e'(instr_i[ILEN-1 -: OP_W]);
    dec_o.ra      = instr_i[ILEN-OP_W-1 -: REG_AW];
    dec_o.rb      = instr_i[ILEN-OP_W-REG_AW-1 -: REG_AW];
    dec_o.rc      = instr_i[REG_AW-1:0];
    dec_o.imm     = (dec_o.op == OP_LUI) ? uimm : simm;
    dec_o.uses_rc = (dec_o.op == OP_ADD) || (dec_o.op == OP_NAND);
    dec_o.halt    = (dec_o.op == OP_JALR) && (instr_i[SIMM_W-1:0] != '0);
    unique case (dec_o.op)
      OP_SW, OP_BEQ: dec_o.wr = 1'b0;
      OP_JALR:       dec_o.wr = !dec_o.halt;
      default:       dec_o.wr = 1'b1;
    endcase
  end
endmodule

// File: rtl/sq16_regfile.sv
module sq16_regfile #(
  parameter int W  = 16,
  parameter int N  = 8,
  localparam int AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra0_i,
  input  logic [AW-1:0] ra1_i,
  output logic [W-1:0]  rd0_o,
  output logic [W-1:0]  rd1_o,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [W-1:0]  wd_i
);
  logic [W-1:0] regs_q [N];

  // entry 0 is cleared by reset and never written
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) regs_q[i] <= '0;
    end else if (we_i) begin
      for (int i = 1; i < N; i++)
        if (wa_i == AW'(i)) regs_q[i] <= wd_i;
    end
  end

  assign rd0_o = regs_q[ra0_i];
  assign rd1_o = regs_q[ra1_i];
endmodule

// File: rtl/sq16_alu.sv
module sq16_alu
  import sq16_pkg::*;
(
  input  op_e             op_i,
  input  logic            uses_rc_i,
  input  logic [ILEN-1:0] opb_i,
  input  logic [ILEN-1:0] opx_i,
  input  logic [ILEN-1:0] imm_i,
  input  logic [ILEN-1:0] mem_rd_i,
  input  logic [ILEN-1:0] link_i,
  output logic [ILEN-1:0] sum_o,
  output logic [ILEN-1:0] wb_o
);
  assign sum_o = opb_i + (uses_rc_i ? opx_i : imm_i);

  always_comb begin
    unique case (op_i)
      OP_NAND: wb_o = ~(opb_i & opx_i);
      OP_LUI:  wb_o = imm_i;
      OP_LW:   wb_o = mem_rd_i;
      OP_JALR: wb_o = link_i;
      default: wb_o = sum_o;
    endcase
  end
endmodule

// File: rtl/sq16_core.sv
module sq16_core
  import sq16_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [ILEN-1:0] imem_addr_o,
  input  logic [ILEN-1:0] imem_data_i,
  output logic [ILEN-1:0] dmem_addr_o,
  output logic [ILEN-1:0] dmem_wdata_o,
  output logic            dmem_we_o,
  input  logic [ILEN-1:0] dmem_rdata_i,
  output logic            halted_o
);
  dec_t            dec;
  logic [ILEN-1:0] pc_q, pc_d, pc_inc;
  logic            halted_q;
  logic [ILEN-1:0] rd_b, rd_x, sum, wb;
  logic            wr_en;

  sq16_decode u_dec (.instr_i(imem_data_i), .dec_o(dec));

  // port 1 reads regC for register forms, regA otherwise
  sq16_regfile #(.W(ILEN), .N(NREG)) u_rf (
    .clk_i, .rst_ni,
    .ra0_i(dec.rb),
    .ra1_i(dec.uses_rc ? dec.rc : dec.ra),
    .rd0_o(rd_b),
    .rd1_o(rd_x),
    .we_i (wr_en),
    .wa_i (dec.ra),
    .wd_i (wb)
  );

  sq16_alu u_alu (
    .op_i(dec.op), .uses_rc_i(dec.uses_rc),
    .opb_i(rd_b), .opx_i(rd_x), .imm_i(dec.imm),
    .mem_rd_i(dmem_rdata_i), .link_i(pc_inc),
    .sum_o(sum), .wb_o(wb)
  );

  assign pc_inc = pc_q + 1'b1;
  assign wr_en  = dec.wr && !halted_q;

  always_comb begin
    pc_d = pc_inc;
    if (halted_q || dec.halt)                  pc_d = pc_q;
    else if (dec.op == OP_JALR)                pc_d = rd_b;
    else if (dec.op == OP_BEQ && rd_b == rd_x) pc_d = pc_inc + dec.imm;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q     <= '0;
      halted_q <= 1'b0;
    end else begin
      pc_q     <= pc_d;
      halted_q <= halted_q || dec.halt;
    end
  end

  assign imem_addr_o  = pc_q;
  assign dmem_addr_o  = sum;
  assign dmem_wdata_o = rd_x;
  assign dmem_we_o    = (dec.op == OP_SW) && !halted_q;
  assign halted_o     = halted_q;
endmodule

// File: rtl/sq16_core_chk.sv
module sq16_core_chk
  import sq16_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic [ILEN-1:0] imem_addr_o,
  input logic [ILEN-1:0] imem_data_i,
  input logic            dmem_we_o,
  input logic            halted_o
);
  logic [OP_W-1:0] op;
  assign op = imem_data_i[ILEN-1 -: OP_W];

  p_halt_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o);

  p_halt_pc_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> $stable(imem_addr_o));

  p_halt_no_store_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !dmem_we_o);

  p_store_only_sw_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_we_o |-> (op == 3'b101));

  p_seq_pc_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halted_o && op < 3'd6) |=> (imem_addr_o == $past(imem_addr_o) + 16'd1));
endmodule

bind sq16_core sq16_core_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .imem_addr_o(imem_addr_o),
  .imem_data_i(imem_data_i), .dmem_we_o(dmem_we_o), .halted_o(halted_o)
);

// File: tb/sq16_core_bench.sv
module sq16_core_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] imem_addr_o, imem_data_i, dmem_addr_o, dmem_wdata_o, dmem_rdata_i;
  logic        dmem_we_o, halted_o;

  logic [15:0] imem [64];
  logic [15:0] dmem [64];

  typedef struct packed { logic [15:0] a; logic [15:0] d; int r; } exp_t;
  exp_t exp_q[$];
  int checks = 0, errors = 0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  sq16_core u_sq16_core (.*);

  assign imem_data_i  = imem[imem_addr_o[5:0]];
  assign dmem_rdata_i = dmem[dmem_addr_o[5:0]];

  always @(posedge clk_i) if (dmem_we_o) dmem[dmem_addr_o[5:0]] <= dmem_wdata_o;

  function automatic logic [15:0] rrr(int op, int a, int b, int c);
    return {3'(op), 3'(a), 3'(b), 4'd0, 3'(c)};
  endfunction
  function automatic logic [15:0] rri(int op, int a, int b, int imm);
    return {3'(op), 3'(a), 3'(b), 7'(imm)};
  endfunction
  function automatic logic [15:0] ri(int op, int a, int imm);
    return {3'(op), 3'(a), 10'(imm)};
  endfunction

  task automatic push_exp(logic [15:0] a, logic [15:0] d, int r);
    exp_q.push_back('{a: a, d: d, r: r});
  endtask

  task automatic check(bit ok, string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: every store must match the scoreboard head
  always @(negedge clk_i) begin
    if (rst_ni && dmem_we_o) begin
      exp_t e;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R10 unexpected store actual=%h:%h expected=none", dmem_addr_o, dmem_wdata_o);
      end else begin
        e = exp_q.pop_front();
        if (dmem_addr_o != e.a || dmem_wdata_o != e.d) begin
          errors++;
          $display("FAIL R%0d store actual=%h:%h expected=%h:%h",
                   e.r, dmem_addr_o, dmem_wdata_o, e.a, e.d);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin imem[i] = 16'h0; dmem[i] = 16'h0; end
    dmem[20] = 16'h1234;
    imem[0]  = rri(1, 1, 0, 5);        // r1=5
    imem[1]  = rri(1, 2, 0, -3);       // r2=FFFD
    imem[2]  = rrr(0, 3, 1, 2);        // r3=2
    imem[3]  = rri(5, 3, 0, 10);
    imem[4]  = rrr(2, 4, 1, 2);        // r4=FFFA
    imem[5]  = rri(5, 4, 0, 11);
    imem[6]  = ri(3, 5, 10'h2AB);      // r5=AAC0
    imem[7]  = rri(5, 5, 0, 12);
    imem[8]  = rri(1, 0, 1, 7);        // write to r0 dropped
    imem[9]  = rri(5, 0, 0, 13);
    imem[10] = rrr(0, 6, 1, 1);        // r6=10
    imem[11] = rri(5, 6, 6, 4);
    imem[12] = rri(5, 1, 6, -2);
    imem[13] = rri(4, 7, 6, 4);        // r7=mem[14]=10
    imem[14] = rri(1, 7, 7, 1);        // r7=11
    imem[15] = rri(5, 7, 0, 15);
    imem[16] = rri(4, 7, 0, 20);       // r7=1234
    imem[17] = rri(5, 7, 0, 16);
    imem[18] = rri(6, 1, 6, 3);        // not taken
    imem[19] = rri(5, 1, 0, 17);
    imem[20] = rri(6, 3, 3, 1);        // taken to 22
    imem[21] = rri(5, 4, 0, 63);       // poison
    imem[22] = rri(5, 3, 0, 18);
    imem[23] = rri(1, 2, 0, 28);
    imem[24] = rri(7, 2, 2, 0);        // jalr r2,r2 -> 28, r2=25
    for (int i = 25; i < 28; i++) imem[i] = rri(5, 4, 0, 63);
    imem[28] = rri(5, 2, 0, 19);
    imem[29] = rri(1, 1, 0, 33);
    imem[30] = rri(7, 3, 1, 0);        // jalr r3,r1 -> 33, r3=31
    imem[31] = rri(5, 4, 0, 63);
    imem[32] = rri(5, 4, 0, 63);
    imem[33] = rri(5, 3, 0, 20);
    imem[34] = rri(1, 4, 0, 2);
    imem[35] = rri(1, 4, 4, -1);
    imem[36] = rri(6, 4, 0, 1);
    imem[37] = rri(6, 0, 0, -3);       // back to 35
    imem[38] = rri(5, 4, 0, 21);
    imem[39] = rri(7, 0, 0, 1);        // halt
    imem[40] = rri(5, 4, 0, 63);

    push_exp(16'd10, 16'h0002, 2);     // R2 add
    push_exp(16'd11, 16'hFFFA, 2);     // R2 nand
    push_exp(16'd12, 16'hAAC0, 4);     // R4
    push_exp(16'd13, 16'h0000, 8);     // R8
    push_exp(16'd14, 16'h000A, 5);     // R5
    push_exp(16'd8,  16'h0005, 5);     // R5 negative offset
    push_exp(16'd15, 16'h000B, 3);     // R3 and load
    push_exp(16'd16, 16'h1234, 5);     // R5
    push_exp(16'd17, 16'h0005, 6);     // R6 not taken
    push_exp(16'd18, 16'h0002, 6);     // R6 taken
    push_exp(16'd19, 16'd25,   7);     // R7 same register
    push_exp(16'd20, 16'd31,   7);     // R7
    push_exp(16'd21, 16'h0000, 6);     // R6 backward loop

    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check(imem_addr_o == 16'd0, "R1 pc", imem_addr_o, 16'd0);
    check(halted_o == 1'b0, "R1 halted", 16'(halted_o), 16'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(imem_addr_o == 16'd1, "R10 first step", imem_addr_o, 16'd1);

    begin
      int n = 0;
      while (!halted_o && n < 2000) begin @(negedge clk_i); n++; end
      if (!halted_o) begin
        errors++; checks++;
        $display("FAIL R9 watchdog actual=%h expected=%h", 16'(halted_o), 16'd1);
      end
    end
    check(imem_addr_o == 16'd39, "R9 halt pc", imem_addr_o, 16'd39);
    repeat (5) @(negedge clk_i);
    check(imem_addr_o == 16'd39, "R9 pc frozen", imem_addr_o, 16'd39);
    check(halted_o == 1'b1, "R9 halted held", 16'(halted_o), 16'd1);
    check(dmem[63] == 16'h0, "R6 R7 poison skipped", dmem[63], 16'h0);
    check(exp_q.size() == 0, "R5 all stores seen", 16'(exp_q.size()), 16'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule